// File: doc/BRIEF.md
# Exception Priority Mask Filter

This block sits between a single pending-exception source and the core's exception entry logic. Each cycle it looks at one request and decides whether it may be taken. The decision uses three mask registers that software writes: a one-bit interrupt mask, a one-bit fault mask and a priority threshold. A request marked non-maskable is always taken, whatever the masks hold. The verdict and the exception number are registered, so a decision appears one cycle after the request is presented.

Priorities are 8 bits wide. Only the top 4 bits count, and a smaller value is more urgent. The threshold register keeps only its top 4 bits, and a threshold of zero turns threshold masking off. A mask write takes effect on decisions from the next cycle onward. A request presented in the same cycle as a write is judged against the old mask values.

Top module: `exc_mask_filter`

## Requirements
- R1: While reset is high and in the cycle after it falls, `take_o` is 0, `num_o` is 0 and `thr_rd_o` reads 0x00. Both mask bits reset to clear.
- R2: With both mask bits clear and the threshold at zero, a request with `req_valid`=1 is taken. This holds for faults and for interrupts. A cycle with `req_valid`=0 yields `take_o`=0.
- R3: While the interrupt mask bit is 1, a request with `req_nmi`=0 and `req_fault`=0 is not taken.
- R4: While the interrupt mask bit is 1, a request with `req_fault`=1 and `req_nmi`=0 is also not taken.
- R5: While the fault mask bit is 1, no request with `req_nmi`=0 is taken, whether or not it is a fault.
- R6: A request with `req_valid`=1 and `req_nmi`=1 is always taken. No setting of the interrupt mask, the fault mask or the threshold blocks it.
- R7: With a non-zero threshold, a request with `req_nmi`=0 passes the threshold only if `req_prio[7:4]` is strictly less than the threshold's bits [7:4]. An equal or larger value blocks the request. This applies to faults and to interrupts.
- R8: A threshold whose bits [7:4] are zero disables threshold masking, so every priority value passes it.
- R9: Bits [3:0] of `req_prio` and of `thr_wdata` have no effect. `thr_rd_o` returns the stored threshold in bits [7:4] with bits [3:0] reading zero.
- R10: A write to any mask register takes effect on requests presented from the cycle after the write. A request presented in the write cycle is judged with the old value.
- R11: `take_o` and `num_o` change one clock after the request they describe. `num_o` carries that request's `req_num` when `take_o`=1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is pending this cycle |
| req_prio | input | 8 | Request priority, smaller is more urgent, bits [7:4] significant |
| req_num | input | 9 | Exception number of the request |
| req_nmi | input | 1 | Request is the non-maskable interrupt |
| req_fault | input | 1 | Request is a fault |
| im_we | input | 1 | Write strobe for the interrupt mask bit |
| im_wdata | input | 1 | New interrupt mask value |
| fm_we | input | 1 | Write strobe for the fault mask bit |
| fm_wdata | input | 1 | New fault mask value |
| thr_we | input | 1 | Write strobe for the priority threshold |
| thr_wdata | input | 8 | New priority threshold value |
| take_o | output | 1 | Registered: the previous cycle's request is taken |
| num_o | output | 9 | Registered exception number of the taken request, else 0 |
| thr_rd_o | output | 8 | Current threshold, low 4 bits zero |

## Verification
The bench checks the boundary where the priority level equals the threshold. A design that compared with less-or-equal would take that request when it should block it. It also sends priorities and thresholds that differ only in their low four bits. A design that used those bits would split cases that ought to behave the same, and it would read back a non-zero low nibble. A fault is sent under the interrupt mask alone, which catches a design that lets faults through that mask. The non-maskable interrupt is sent under every mask combination, which catches any mask that is not bypassed for it. A request is also placed in the same cycle as a mask write, to catch a write that reaches the decision path one cycle too early.

// File: rtl/exc_mask_pkg.sv
package exc_mask_pkg;

    parameter int PRIO_W    = 8;
    parameter int PRIO_BITS = 4;
    parameter int NUM_W     = 9;

    localparam int PRIO_LSB = PRIO_W - PRIO_BITS;

    typedef logic [PRIO_W-1:0]    prio_t;
    typedef logic [PRIO_BITS-1:0] level_t;
    typedef logic [NUM_W-1:0]     exc_num_t;

    typedef struct packed {
        logic     valid;
        logic     nmi;
        logic     fault;
        prio_t    prio;
        exc_num_t num;
    } exc_req_t;

    typedef struct packed {
        logic   im;
        logic   fm;
        level_t thr;
    } mask_state_t;

    typedef enum logic [2:0] {
        V_IDLE     = 3'd0,
        V_TAKE_NMI = 3'd1,
        V_TAKE     = 3'd2,
        V_BLK_FM   = 3'd3,
        V_BLK_IM   = 3'd4,
        V_BLK_THR  = 3'd5
    } verdict_e;

    function automatic level_t prio_level(input prio_t p);
        return p[PRIO_W-1 -: PRIO_BITS];
    endfunction

    function automatic logic thr_open(input level_t lvl, input level_t thr);
        return (thr == '0) || (lvl < thr);
    endfunction

    function automatic verdict_e judge(input exc_req_t r, input mask_state_t m);
        verdict_e v;
        if (!r.valid)                              v = V_IDLE;
        else if (r.nmi)                            v = V_TAKE_NMI;
        else if (m.fm)                             v = V_BLK_FM;
        else if (m.im)                             v = V_BLK_IM;
        else if (!thr_open(prio_level(r.prio), m.thr)) v = V_BLK_THR;
        else                                       v = V_TAKE;
        return v;
    endfunction

    function automatic logic is_take(input verdict_e v);
        return (v == V_TAKE) || (v == V_TAKE_NMI);
    endfunction

endpackage

// File: rtl/exc_mask_regs.sv
module exc_mask_regs
    import exc_mask_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        im_we,
    input  logic        im_wdata,
    input  logic        fm_we,
    input  logic        fm_wdata,
    input  logic        thr_we,
    input  prio_t       thr_wdata,
    output mask_state_t masks
);

    mask_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (im_we)  st_q.im  <= im_wdata;
            if (fm_we)  st_q.fm  <= fm_wdata;
            if (thr_we) st_q.thr <= prio_level(thr_wdata);
        end
    end

    assign masks = st_q;

endmodule

// File: rtl/exc_mask_decide.sv
module exc_mask_decide
    import exc_mask_pkg::*;
(
    input  exc_req_t    req,
    input  mask_state_t masks,
    output verdict_e    verdict
);

    always_comb begin
        verdict = judge(req, masks);
    end

endmodule

// File: rtl/exc_take_stage.sv
module exc_take_stage
    import exc_mask_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_e verdict,
    input  exc_num_t num_in,
    output logic     take_o,
    output exc_num_t num_o
);

    logic     take_q;
    exc_num_t num_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
            num_q  <= '0;
        end else begin
            take_q <= is_take(verdict);
            num_q  <= is_take(verdict) ? num_in : '0;
        end
    end

    assign take_o = take_q;
    assign num_o  = num_q;

endmodule

// File: rtl/exc_mask_filter.sv
module exc_mask_filter
    import exc_mask_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [PRIO_W-1:0]    req_prio,
    input  logic [NUM_W-1:0]     req_num,
    input  logic                 req_nmi,
    input  logic                 req_fault,
    input  logic                 im_we,
    input  logic                 im_wdata,
    input  logic                 fm_we,
    input  logic                 fm_wdata,
    input  logic                 thr_we,
    input  logic [PRIO_W-1:0]    thr_wdata,
    output logic                 take_o,
    output logic [NUM_W-1:0]     num_o,
    output logic [PRIO_W-1:0]    thr_rd_o
);

    exc_req_t    req;
    mask_state_t mask_st;
    verdict_e    verdict;

    assign req = '{valid: req_valid, nmi: req_nmi, fault: req_fault,
                   prio: req_prio, num: req_num};

    exc_mask_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .im_we     (im_we),
        .im_wdata  (im_wdata),
        .fm_we     (fm_we),
        .fm_wdata  (fm_wdata),
        .thr_we    (thr_we),
        .thr_wdata (thr_wdata),
        .masks     (mask_st)
    );

    exc_mask_decide u_decide (
        .req     (req),
        .masks   (mask_st),
        .verdict (verdict)
    );

    exc_take_stage u_take (
        .clk     (clk),
        .rst     (rst),
        .verdict (verdict),
        .num_in  (req.num),
        .take_o  (take_o),
        .num_o   (num_o)
    );

    generate
        if (PRIO_LSB > 0) begin : g_pad
            assign thr_rd_o = {mask_st.thr, {PRIO_LSB{1'b0}}};
        end else begin : g_nopad
            assign thr_rd_o = mask_st.thr;
        end
    endgenerate

endmodule

// File: rtl/exc_mask_filter_chk.sv
module exc_mask_filter_chk
    import exc_mask_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_nmi,
    input prio_t       req_prio,
    input exc_num_t    req_num,
    input logic        take_o,
    input exc_num_t    num_o,
    input mask_state_t masks
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!take_o && num_o == '0));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!take_o && num_o == '0));

    p_open_take_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !masks.im && !masks.fm && masks.thr == '0) |=> take_o);

    p_im_block_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_nmi && masks.im) |=> !take_o);

    p_fm_block_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_nmi && masks.fm) |=> !take_o);

    p_nmi_take_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_nmi) |=> take_o);

    p_thr_block_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_nmi && masks.thr != '0 &&
         prio_level(req_prio) >= masks.thr) |=> !take_o);

    p_num_follow_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!take_o || num_o == $past(req_num)));

endmodule

bind exc_mask_filter exc_mask_filter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_nmi   (req_nmi),
    .req_prio  (req_prio),
    .req_num   (req_num),
    .take_o    (take_o),
    .num_o     (num_o),
    .masks     (mask_st)
);

// File: tb/tb_exc_mask_filter.sv
`timescale 1ns/1ps
module tb_exc_mask_filter;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid, req_nmi, req_fault;
    logic [7:0] req_prio;
    logic [8:0] req_num;
    logic       im_we, im_wdata, fm_we, fm_wdata, thr_we;
    logic [7:0] thr_wdata;
    logic       take_o;
    logic [8:0] num_o;
    logic [7:0] thr_rd_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    exc_mask_filter dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_prio(req_prio),
        .req_num(req_num), .req_nmi(req_nmi), .req_fault(req_fault),
        .im_we(im_we), .im_wdata(im_wdata), .fm_we(fm_we), .fm_wdata(fm_wdata),
        .thr_we(thr_we), .thr_wdata(thr_wdata),
        .take_o(take_o), .num_o(num_o), .thr_rd_o(thr_rd_o)
    );

    typedef struct {
        logic       take;
        logic [8:0] num;
        logic [7:0] thr;
        string      tag;
    } exp_t;

    exp_t q[$];

    logic       m_im, m_fm;
    logic [3:0] m_thr;

    task automatic step(input logic v, input logic nmi, input logic flt,
                        input logic [7:0] prio, input logic [8:0] num,
                        input logic imw, input logic imd,
                        input logic fmw, input logic fmd,
                        input logic tw, input logic [7:0] td,
                        input string tag);
        exp_t e;
        logic ok;
        @(negedge clk);
        req_valid = v; req_nmi = nmi; req_fault = flt;
        req_prio = prio; req_num = num;
        im_we = imw; im_wdata = imd; fm_we = fmw; fm_wdata = fmd;
        thr_we = tw; thr_wdata = td;
        ok = nmi || (!m_fm && !m_im && (m_thr == 4'd0 || prio[7:4] < m_thr));
        e.take = v && ok;
        e.num  = e.take ? num : 9'd0;
        if (imw) m_im = imd;
        if (fmw) m_fm = fmd;
        if (tw)  m_thr = td[7:4];
        e.thr = {m_thr, 4'b0000};
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic req(input logic nmi, input logic flt, input logic [7:0] prio,
                       input logic [8:0] num, input string tag);
        step(1'b1, nmi, flt, prio, num, 0, 0, 0, 0, 0, 8'h00, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 0, 0, 8'h00, 9'd0, 0, 0, 0, 0, 0, 8'h00, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_checks++;
                if (take_o !== e.take || num_o !== e.num || thr_rd_o !== e.thr) begin
                    n_fail++;
                    $display("FAIL %s: take=%0b num=%0d thr=%h expected take=%0b num=%0d thr=%h",
                             e.tag, take_o, num_o, thr_rd_o, e.take, e.num, e.thr);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        m_im = 0; m_fm = 0; m_thr = 4'd0;
        rst = 1'b1;
        req_valid = 0; req_nmi = 0; req_fault = 0; req_prio = 0; req_num = 0;
        im_we = 0; im_wdata = 0; fm_we = 0; fm_wdata = 0; thr_we = 0; thr_wdata = 0;
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (take_o !== 1'b0 || num_o !== 9'd0 || thr_rd_o !== 8'h00) begin
            n_fail++;
            $display("FAIL R1 reset: take=%0b num=%0d thr=%h expected 0 0 00",
                     take_o, num_o, thr_rd_o);
        end
        @(negedge clk);
        rst = 1'b0;
        idle("R1 after reset");

        req(0, 0, 8'h40, 9'd17, "R2 open irq");
        idle("R2 idle");
        req(0, 1, 8'hF0, 9'd3,  "R2 open fault");
        req(0, 0, 8'h00, 9'd99, "R11 back-to-back a");
        req(0, 0, 8'h10, 9'd300,"R11 back-to-back b");

        step(1, 0, 0, 8'h20, 9'd20, 1, 1, 0, 0, 0, 8'h00, "R10 im write same cycle");
        req(0, 0, 8'h00, 9'd21, "R3 im blocks irq");
        req(0, 1, 8'h00, 9'd5,  "R4 im blocks fault");
        req(1, 0, 8'hF0, 9'd2,  "R6 nmi under im");
        step(0, 0, 0, 8'h00, 9'd0, 1, 0, 0, 0, 0, 8'h00, "R10 im clear");
        req(0, 0, 8'h00, 9'd22, "R10 im cleared");

        step(0, 0, 0, 8'h00, 9'd0, 0, 0, 1, 1, 0, 8'h00, "R5 fm set");
        req(0, 0, 8'h00, 9'd23, "R5 fm blocks irq");
        req(0, 1, 8'h00, 9'd6,  "R5 fm blocks fault");
        req(1, 0, 8'h80, 9'd2,  "R6 nmi under fm");
        step(0, 0, 0, 8'h00, 9'd0, 1, 1, 0, 0, 1, 8'h10, "R6 set all masks");
        req(1, 1, 8'hFF, 9'd2,  "R6 nmi under all masks");
        step(1, 0, 0, 8'h00, 9'd24, 1, 0, 1, 0, 0, 8'h00, "R10 clear both same cycle");
        step(0, 0, 0, 8'h00, 9'd0, 0, 0, 0, 0, 1, 8'h00, "R8 thr zero");

        step(1, 0, 0, 8'h50, 9'd30, 0, 0, 0, 0, 1, 8'h50, "R10 thr write same cycle");
        req(0, 0, 8'h50, 9'd31, "R7 equal blocked");
        req(0, 0, 8'h40, 9'd32, "R7 more urgent taken");
        req(0, 0, 8'h60, 9'd33, "R7 less urgent blocked");
        req(0, 0, 8'h4F, 9'd34, "R9 low bits prio taken");
        req(0, 0, 8'h5F, 9'd35, "R9 low bits prio blocked");
        req(0, 1, 8'h70, 9'd7,  "R7 fault blocked by thr");
        req(0, 1, 8'h00, 9'd8,  "R7 fault passes thr");
        req(1, 0, 8'hF0, 9'd2,  "R6 nmi under thr");
        step(0, 0, 0, 8'h00, 9'd0, 0, 0, 0, 0, 1, 8'h57, "R9 thr low bits drop");
        req(0, 0, 8'h4A, 9'd36, "R9 thr 57 acts as 50");
        req(0, 0, 8'h50, 9'd37, "R9 thr 57 blocks 50");
        step(0, 0, 0, 8'h00, 9'd0, 0, 0, 0, 0, 1, 8'h10, "R7 thr one");
        req(0, 0, 8'h00, 9'd38, "R7 level zero under thr one");
        req(0, 0, 8'h10, 9'd39, "R7 level one blocked");

        step(0, 0, 0, 8'h00, 9'd0, 0, 0, 0, 0, 1, 8'h0F, "R9 thr 0F reads zero");
        req(0, 0, 8'hF0, 9'd40, "R8 thr zero lowest urgency taken");
        req(0, 0, 8'hFF, 9'd41, "R8 thr zero ff taken");
        idle("R2 final idle");
        idle("R2 drain");

        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule